// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block is the sending half of a PS/2 device (mouse or keyboard side). It takes a chunk of one to `MAX_BYTES` bytes from a parallel valid/ready port and serializes each byte as an 11-bit frame on the PS/2 clock and data lines. It generates the PS/2 clock itself and drives both lines only through open-drain enables: an asserted enable pulls the line low, a released enable lets the pull-up take it high. The sensed level of the clock line returns on `ps2_clk_in`. A local divider turns the system clock into the bit timing, and two parameters set the system clock in cycles per microsecond and the half-period of the PS/2 clock in microseconds.

The host may hold the clock line low at any time to inhibit the link, and the transmitter watches for that. Before every byte the line must have been high for a quiet interval. If the host pulls the clock low part way through a frame, the transmitter lets go of both lines, reports `aborted`, and later sends the whole chunk again from its first byte. An inhibit that comes before a byte's first clock pulse, or in the gap after a finished byte, only delays the transfer. A one-cycle `done` pulse marks the end of the last frame of a chunk. While the transmitter waits for the host to release the line, a newly offered chunk replaces the pending one, so only the latest data is kept.

Top module: `ps2_dev_tx`

## Requirements
- R1: Each frame carries, in time order: a start bit of 0, the eight data bits least significant first, a parity bit, and a stop bit of 1. A 0 bit is sent with `ps2_dat_oe` = 1 and a 1 bit with `ps2_dat_oe` = 0. The host reads each bit while `ps2_clk_oe` is asserted.
- R2: The parity bit makes the count of ones over the eight data bits plus parity odd.
- R3: During a frame, the clock is held low (`ps2_clk_oe` = 1) for exactly `CLK_PER_US*HALF_US` cycles per pulse. The clock pulses are `2*CLK_PER_US*HALF_US` cycles apart. `HALF_US` is limited to 30..50, which keeps the rate between 10 and 16.7 kHz.
- R4: `ps2_dat_oe` changes only while the clock is released. It stays stable for the whole of every low phase.
- R5: A byte starts, shown by the start bit appearing on `ps2_dat_oe`, only after the sensed clock line has been continuously high for at least `IDLE_US` microseconds. A shorter release does not start a frame.
- R6: A low sensed clock while the transmitter releases it, after the byte's first falling edge and before its eleventh, aborts the byte. Both enables are released, `aborted` pulses for one cycle, and the whole chunk is sent again from its first byte once the line has been quiet.
- R7: An inhibit before a byte's first falling edge gives no `aborted` pulse. That byte is sent once, later.
- R8: An inhibit after a byte's eleventh clock pulse and before the next byte of the same chunk does not resend the finished byte.
- R9: `done` is a one-cycle pulse. It rises in the cycle in which the clock is released after the final pulse of the chunk's last frame.
- R10: `in_ready` is 1 only while no byte is on the line and no chunk is partly sent. A byte offered while `in_ready` = 0 has no effect on what is sent.
- R11: A chunk offered while an earlier complete chunk is still waiting to start replaces the earlier one.
- R12: After reset, both enables are released, `done` and `aborted` are 0 and `in_ready` is 1.
- R13: A chunk ends at a byte with `in_last` = 1 or at the `MAX_BYTES`-th byte, whichever comes first. All its bytes are sent in the order they were offered, with a single `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Byte offered for the current chunk |
| in_valid | input | 1 | `in_byte` is valid |
| in_last | input | 1 | Offered byte closes the chunk |
| in_ready | output | 1 | A byte is taken when `in_valid` and `in_ready` are both 1 |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock line (asynchronous) |
| ps2_clk_oe | output | 1 | Pull the PS/2 clock line low |
| ps2_dat_oe | output | 1 | Pull the PS/2 data line low |
| done | output | 1 | Chunk fully sent (one-cycle pulse) |
| aborted | output | 1 | Frame cut by a host inhibit; chunk will be resent (one-cycle pulse) |

## Verification
The hardest case to reach is an inhibit that lands inside the second byte of a chunk, after the first byte has already gone out. Only that case shows that the retransmission really starts again from byte zero. The bench follows the clock enable and counts completed frames and clock pulses. Once the first byte has finished and a set number of pulses of the second byte have passed, it pulls the modelled clock line low part way into a released phase and holds it long enough to count as an inhibit. The same pulse-counting approach places inhibits just before a byte's first pulse and in the quiet gap between two bytes, so those two harmless cases can be told apart from a real abort.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

   // Bits per serial frame: start, eight data, parity, stop.
   localparam int FRAME_BITS = 11;
   localparam int LAST_BIT   = FRAME_BITS - 1;

   typedef enum logic {
      TX_WAIT,
      TX_SEND
   } tx_state_e;

   typedef enum logic {
      PH_REL,   // clock released (line high)
      PH_PULL   // clock pulled low
   } tx_phase_e;

   // Frame vector in transmit order, bit 0 leaves first.
   function automatic logic [FRAME_BITS-1:0] frame_of(input logic [7:0] b);
      return {1'b1, ~(^b), b, 1'b0};
   endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ps2tx_sync: STAGES must be at least 2");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) pipe[0] <= 1'b1;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) pipe[s] <= 1'b1;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/ps2tx_span.sv
// Saturating cycle counter: hit is high once LIMIT cycles have elapsed
// since the last clear.
module ps2tx_span #(
   parameter  int LIMIT = 1,
   localparam int W     = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);

   logic [W-1:0] cnt;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("ps2tx_span: LIMIT must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)          cnt <= '0;
      else if (cnt != W'(LIMIT))  cnt <= cnt + 1'b1;
   end

   assign hit = (cnt == W'(LIMIT));

endmodule

// File: rtl/ps2tx_chunk_buf.sv
// Holds one chunk of up to MAX_BYTES bytes. A push after a complete chunk
// (or into an empty buffer) starts a fresh chunk, discarding the old one.
module ps2tx_chunk_buf #(
   parameter  int MAX_BYTES = 3,
   localparam int CW        = $clog2(MAX_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [7:0]    push_byte,
   input  logic          push_last,
   input  logic          clear,
   input  logic [CW-1:0] rd_idx,
   output logic [7:0]    rd_byte,
   output logic [CW-1:0] n_bytes,
   output logic          complete
);

   logic [CW-1:0]            cnt;
   logic                     full;
   logic                     fresh;
   logic [CW-1:0]            wr_idx;
   logic [CW-1:0]            cnt_nxt;
   logic [MAX_BYTES*8-1:0]   slots;

   assign fresh   = full || (cnt == '0);
   assign wr_idx  = fresh ? '0 : cnt;
   assign cnt_nxt = wr_idx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt  <= '0;
         full <= 1'b0;
      end else if (push) begin
         cnt  <= cnt_nxt;
         full <= push_last || (cnt_nxt == CW'(MAX_BYTES));
      end
   end

   generate
      for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
         logic [7:0] held;
         always_ff @(posedge clk) begin
            if (!rst_n)                              held <= '0;
            else if (push && (wr_idx == CW'(g)))     held <= push_byte;
         end
         assign slots[g*8 +: 8] = held;
      end
   endgenerate

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < MAX_BYTES; i++) begin
         if (rd_idx == CW'(i)) rd_byte = slots[i*8 +: 8];
      end
   end

   assign n_bytes  = cnt;
   assign complete = full;

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
   import ps2tx_pkg::*;
#(
   parameter int CLK_PER_US  = 50,
   parameter int HALF_US     = 40,
   parameter int IDLE_US     = 50,
   parameter int MAX_BYTES   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_byte,
   input  logic       in_valid,
   input  logic       in_last,
   output logic       in_ready,
   input  logic       ps2_clk_in,
   output logic       ps2_clk_oe,
   output logic       ps2_dat_oe,
   output logic       done,
   output logic       aborted
);

   localparam int HALF_CYC = CLK_PER_US * HALF_US;
   localparam int IDLE_CYC = CLK_PER_US * IDLE_US;
   localparam int GUARD    = SYNC_STAGES + 1;
   localparam int CW       = $clog2(MAX_BYTES + 1);

   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("ps2_dev_tx: CLK_PER_US must be positive");
      end
      if (HALF_US < 30 || HALF_US > 50) begin : g_bad_half
         $error("ps2_dev_tx: HALF_US outside the 10..16.7 kHz range");
      end
      if (IDLE_US < 50) begin : g_bad_idle
         $error("ps2_dev_tx: IDLE_US below the 50 us quiet time");
      end
      if (MAX_BYTES < 1 || MAX_BYTES > 8) begin : g_bad_bytes
         $error("ps2_dev_tx: MAX_BYTES must be 1..8");
      end
      if (GUARD >= HALF_CYC) begin : g_bad_guard
         $error("ps2_dev_tx: synchronizer delay exceeds a half period");
      end
   endgenerate

   tx_state_e        state;
   tx_phase_e        phase;
   logic [3:0]       bit_idx;
   logic [CW-1:0]    byte_idx;
   logic             done_q;
   logic             abort_q;

   logic             line_hi;
   logic             half_hit;
   logic             guard_ok;
   logic             quiet_ok;
   logic             half_clr;

   logic [7:0]       cur_byte;
   logic [CW-1:0]    n_bytes;
   logic             chunk_ready;
   logic [FRAME_BITS-1:0] frame;
   logic             cur_bit;

   logic             accept;
   logic             start;
   logic             inhibit;
   logic             last_byte;
   logic             byte_end;
   logic             chunk_end;

   // ---------------- line sensing and timing ----------------
   ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ps2_clk_in),
      .q     (line_hi)
   );

   assign half_clr = (state != TX_SEND) || half_hit;

   ps2tx_span #(.LIMIT(HALF_CYC - 1)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (half_clr),
      .hit   (half_hit)
   );

   // Ignore the sensed line until the synchronizer has seen our release.
   ps2tx_span #(.LIMIT(GUARD)) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (half_clr),
      .hit   (guard_ok)
   );

   ps2tx_span #(.LIMIT(IDLE_CYC)) u_quiet (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((state == TX_SEND) || !line_hi),
      .hit   (quiet_ok)
   );

   // ---------------- chunk storage ----------------
   assign in_ready = (state == TX_WAIT) && (byte_idx == '0);
   assign accept   = in_valid && in_ready;

   ps2tx_chunk_buf #(.MAX_BYTES(MAX_BYTES)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_byte (in_byte),
      .push_last (in_last),
      .clear     (chunk_end),
      .rd_idx    (byte_idx),
      .rd_byte   (cur_byte),
      .n_bytes   (n_bytes),
      .complete  (chunk_ready)
   );

   // ---------------- frame sequencing ----------------
   assign frame     = frame_of(cur_byte);
   assign cur_bit   = frame[bit_idx];
   assign last_byte = ((byte_idx + CW'(1)) == n_bytes);

   assign start   = (state == TX_WAIT) && chunk_ready && quiet_ok && !accept;
   assign inhibit = (state == TX_SEND) && (phase == PH_REL) && guard_ok && !line_hi;
   assign byte_end  = (state == TX_SEND) && !inhibit && half_hit &&
                      (phase == PH_PULL) && (bit_idx == 4'(LAST_BIT));
   assign chunk_end = byte_end && last_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= TX_WAIT;
         phase    <= PH_REL;
         bit_idx  <= '0;
         byte_idx <= '0;
         done_q   <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         done_q  <= chunk_end;
         abort_q <= 1'b0;
         unique case (state)
            TX_WAIT: begin
               if (start) begin
                  state   <= TX_SEND;
                  phase   <= PH_REL;
                  bit_idx <= '0;
               end
            end
            TX_SEND: begin
               if (inhibit) begin
                  state <= TX_WAIT;
                  phase <= PH_REL;
                  if (bit_idx != '0) begin
                     abort_q  <= 1'b1;
                     byte_idx <= '0;
                  end
               end else if (half_hit) begin
                  if (phase == PH_REL) begin
                     phase <= PH_PULL;
                  end else begin
                     phase <= PH_REL;
                     if (bit_idx == 4'(LAST_BIT)) begin
                        state    <= TX_WAIT;
                        bit_idx  <= '0;
                        byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end
               end
            end
            default: state <= TX_WAIT;
         endcase
      end
   end

   assign ps2_clk_oe = (state == TX_SEND) && (phase == PH_PULL);
   assign ps2_dat_oe = (state == TX_SEND) && !cur_bit;
   assign done       = done_q;
   assign aborted    = abort_q;

endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
   parameter int HALF_CYC = 2000
) (
   input logic clk,
   input logic rst_n,
   input logic ps2_clk_oe,
   input logic ps2_dat_oe,
   input logic in_ready,
   input logic done,
   input logic aborted
);

   int unsigned low_len;

   always_ff @(posedge clk) begin
      if (!rst_n)          low_len <= 0;
      else if (ps2_clk_oe) low_len <= low_len + 1;
      else                 low_len <= 0;
   end

   // R4
   dat_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ps2_clk_oe && $past(ps2_clk_oe)) |-> $stable(ps2_dat_oe));

   // R3
   low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps2_clk_oe) |-> (low_len == HALF_CYC));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_vs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && aborted));

   // R6
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aborted |-> (!ps2_clk_oe && !ps2_dat_oe));

   // R10
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!ps2_clk_oe && !ps2_dat_oe));

endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ps2_clk_oe (ps2_clk_oe),
   .ps2_dat_oe (ps2_dat_oe),
   .in_ready   (in_ready),
   .done       (done),
   .aborted    (aborted)
);

// File: tb/ps2_dev_tx_tb.sv
module ps2_dev_tx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CPU   = 2;
   localparam int HUS   = 40;
   localparam int IUS   = 50;
   localparam int HALF  = CPU * HUS;
   localparam int IDLE  = CPU * IUS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_byte = '0;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       ps2_clk_oe;
   logic       ps2_dat_oe;
   logic       done;
   logic       aborted;
   logic       host_inh = 1'b0;
   logic       line_clk;

   assign line_clk = !(ps2_clk_oe || host_inh);

   always #(CLK_PERIOD/2) clk = ~clk;

   ps2_dev_tx #(
      .CLK_PER_US (CPU),
      .HALF_US    (HUS),
      .IDLE_US    (IUS),
      .MAX_BYTES  (3),
      .SYNC_STAGES(2)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_byte    (in_byte),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .in_ready   (in_ready),
      .ps2_clk_in (line_clk),
      .ps2_clk_oe (ps2_clk_oe),
      .ps2_dat_oe (ps2_dat_oe),
      .done       (done),
      .aborted    (aborted)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // ---------------- line monitor ----------------
   logic [7:0]  cap [0:63];
   int          ncap = 0;
   int          n_rise = 0;
   int          n_done = 0;
   int          n_abort = 0;
   int          frame_err = 0;
   int          par_err = 0;
   int          period_err = 0;
   int          hold_err = 0;
   logic [10:0] bits;
   int          nbits = 0;
   int          since = 0;
   logic        prev_oe = 1'b0;
   logic        prev_dat = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         since = since + 1;
         if (since > 3*HALF) nbits = 0;
         if (ps2_clk_oe && prev_oe && (ps2_dat_oe != prev_dat)) hold_err++;
         if (ps2_clk_oe && !prev_oe) begin
            n_rise++;
            if (nbits > 0 && since != 2*HALF) period_err++;
            since = 0;
            bits[nbits] = !ps2_dat_oe;
            nbits = nbits + 1;
            if (nbits == 11) begin
               if (bits[0] != 1'b0 || bits[10] != 1'b1) frame_err++;
               if ((^bits[9:1]) != 1'b1) par_err++;
               cap[ncap[5:0]] = bits[8:1];
               ncap++;
               nbits = 0;
            end
         end
         if (done)    n_done++;
         if (aborted) n_abort++;
         prev_oe  = ps2_clk_oe;
         prev_dat = ps2_dat_oe;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_cap(input int idx, input logic [7:0] exp, input string req);
      chk(idx < ncap && cap[idx[5:0]] == exp, req,
          (idx < ncap) ? int'(cap[idx[5:0]]) : -1, int'(exp));
   endtask

   task automatic offer(input logic [7:0] b, input logic last);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_byte  = b;
      in_valid = 1'b1;
      in_last  = last;
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_done();
      int d0;
      d0 = n_done;
      while (n_done == d0) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(!ps2_clk_oe && !ps2_dat_oe, "R12 lines released", {ps2_clk_oe, ps2_dat_oe}, 0);
      chk(!done && !aborted, "R12 pulses low", {done, aborted}, 0);
      chk(in_ready, "R12 ready", in_ready, 1);
   endtask

   task automatic t_single(input logic [7:0] b);
      int base;
      logic pr;
      bit seen;
      base = ncap;
      seen = 0;
      pr = 1'b0;
      offer(b, 1'b1);
      while (!seen) begin
         @(negedge clk);
         if (done) begin
            seen = 1;
            // R9: done appears with the release after the last low phase
            chk(pr && !ps2_clk_oe, "R9 done at final release", {pr, ps2_clk_oe}, 2);
         end
         pr = ps2_clk_oe;
      end
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      repeat (20) @(negedge clk);
      chk(ncap - base == 1, "R1 one frame", ncap - base, 1);
      chk_cap(base, b, "R1 data LSB first");
   endtask

   task automatic t_chunk3();
      int base, d0;
      base = ncap;
      d0 = n_done;
      offer(8'h08, 1'b0);
      offer(8'h12, 1'b0);
      offer(8'hF0, 1'b0);   // third byte closes the chunk (R13)
      wait_done();
      chk(ncap - base == 3, "R13 three frames", ncap - base, 3);
      chk_cap(base,     8'h08, "R13 byte0");
      chk_cap(base + 1, 8'h12, "R13 byte1");
      chk_cap(base + 2, 8'hF0, "R13 byte2");
      chk(n_done - d0 == 1, "R13 single done", n_done - d0, 1);
   endtask

   task automatic t_quiet();
      int r0, dly;
      bit started;
      host_inh = 1'b1;
      repeat (5) @(negedge clk);
      offer(8'h3C, 1'b1);
      r0 = n_rise;
      started = 0;
      repeat (300) begin
         @(negedge clk);
         if (ps2_dat_oe) started = 1;
      end
      // short release, below the quiet time
      host_inh = 1'b0;
      repeat (IDLE - 40) begin
         @(negedge clk);
         if (ps2_dat_oe) started = 1;
      end
      host_inh = 1'b1;
      repeat (50) begin
         @(negedge clk);
         if (ps2_dat_oe) started = 1;
      end
      chk(!started && n_rise == r0, "R5 no start while inhibited", started, 0);
      host_inh = 1'b0;
      dly = 0;
      while (!ps2_dat_oe && dly < 1000) begin
         @(negedge clk);
         dly++;
      end
      chk(dly >= IDLE && dly <= IDLE + 6, "R5 quiet delay", dly, IDLE + 3);
      wait_done();
      chk_cap(ncap - 1, 8'h3C, "R5 byte after quiet");
   endtask

   task automatic t_abort();
      int base, a0, d0, r0;
      base = ncap;
      a0 = n_abort;
      d0 = n_done;
      offer(8'h11, 1'b0);
      offer(8'h22, 1'b1);
      while (ncap == base) @(negedge clk);
      r0 = n_rise;
      while (n_rise < r0 + 4) @(negedge clk);
      while (ps2_clk_oe) @(negedge clk);
      repeat (10) @(negedge clk);
      host_inh = 1'b1;
      repeat (300) @(negedge clk);
      host_inh = 1'b0;
      wait_done();
      chk(n_abort - a0 == 1, "R6 aborted pulse", n_abort - a0, 1);
      chk(ncap - base == 3, "R6 frames incl resend", ncap - base, 3);
      chk_cap(base + 1, 8'h11, "R6 resend from first byte");
      chk_cap(base + 2, 8'h22, "R6 second byte after resend");
      chk(n_done - d0 == 1, "R6 one done", n_done - d0, 1);
   endtask

   task automatic t_early();
      int base, a0, r0;
      base = ncap;
      a0 = n_abort;
      offer(8'h5A, 1'b1);
      while (!ps2_dat_oe) @(negedge clk);
      r0 = n_rise;
      repeat (10) @(negedge clk);
      host_inh = 1'b1;
      repeat (200) @(negedge clk);
      chk(n_rise == r0, "R7 no pulse before inhibit", n_rise - r0, 0);
      host_inh = 1'b0;
      wait_done();
      chk(n_abort == a0, "R7 no abort", n_abort - a0, 0);
      chk(ncap - base == 1, "R7 sent once", ncap - base, 1);
      chk_cap(base, 8'h5A, "R7 byte value");
   endtask

   task automatic t_between();
      int base, a0;
      base = ncap;
      a0 = n_abort;
      offer(8'h81, 1'b0);
      offer(8'h7E, 1'b1);
      while (ncap == base) @(negedge clk);
      while (ps2_clk_oe) @(negedge clk);
      repeat (5) @(negedge clk);
      host_inh = 1'b1;
      repeat (200) @(negedge clk);
      host_inh = 1'b0;
      wait_done();
      chk(n_abort == a0, "R8 no abort", n_abort - a0, 0);
      chk(ncap - base == 2, "R8 no resend", ncap - base, 2);
      chk_cap(base,     8'h81, "R8 byte0");
      chk_cap(base + 1, 8'h7E, "R8 byte1");
   endtask

   task automatic t_replace();
      int base, d0;
      base = ncap;
      d0 = n_done;
      host_inh = 1'b1;
      repeat (5) @(negedge clk);
      offer(8'h44, 1'b1);
      offer(8'h9C, 1'b0);
      offer(8'h3F, 1'b1);
      repeat (20) @(negedge clk);
      host_inh = 1'b0;
      wait_done();
      chk(ncap - base == 2, "R11 only latest chunk", ncap - base, 2);
      chk_cap(base,     8'h9C, "R11 byte0");
      chk_cap(base + 1, 8'h3F, "R11 byte1");
      chk(n_done - d0 == 1, "R11 one done", n_done - d0, 1);
   endtask

   task automatic t_busy();
      int base, r0;
      base = ncap;
      r0 = n_rise;
      offer(8'hC3, 1'b1);
      while (!ps2_dat_oe) @(negedge clk);
      chk(!in_ready, "R10 not ready while sending", in_ready, 0);
      in_byte  = 8'h00;
      in_valid = 1'b1;
      in_last  = 1'b1;
      repeat (5) @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      wait_done();
      repeat (400) @(negedge clk);
      chk(ncap - base == 1, "R10 ignored offer", ncap - base, 1);
      chk_cap(base, 8'hC3, "R10 byte kept");
      chk(n_rise - r0 == 11, "R10 pulse count", n_rise - r0, 11);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   // ---------------- main ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single(8'hA5);
      t_single(8'h00);
      t_single(8'hFF);
      t_chunk3();
      t_quiet();
      t_abort();
      t_early();
      t_between();
      t_replace();
      t_busy();
      chk(frame_err == 0, "R1 start/stop bits", frame_err, 0);
      chk(par_err == 0, "R2 odd parity", par_err, 0);
      chk(period_err == 0, "R3 pulse spacing", period_err, 0);
      chk(hold_err == 0, "R4 data stable in low phase", hold_err, 0);
      finished = 1;
      summary();
      $finish;
   end

endmodule